// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt sources and presents one active-low request line to a processor core. Each source has a mode word and a vector word. The mode word holds a 3-bit priority and a 2-bit trigger type. The vector word is returned to software when that source is acknowledged. Sources can be level or edge sensitive. Low-level and falling-edge sensing are only available on sources that a parameter marks as external pins.

Software uses a simple word-addressed register bus. Reading the vector port acknowledges the best pending source and returns its vector. It also pushes that source's priority onto an eight-entry nesting stack, so only strictly higher priorities can interrupt the core until service ends. A write of any value to the end-of-service port pops one stack level. When nothing qualifies, the vector port returns a programmable spurious vector and the stack is left alone. Per-source enable, disable and clear actions are bitmask writes.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset all sources are disabled, the stack is empty, the spurious vector, all vectors and all mode words are 0, `irq_n` is high, and reads of the vector port (64), status (65), pending (66) and enable (67) words return 0.
- R2: A write to word 68 sets the enable bits where the data is 1. A write to word 69 clears them where the data is 1. A write to word 70 clears the latched edge-pending bits where the data is 1. Word 67 reads the enable mask, so writing all ones to 69 disables every source.
- R3: Mode word i (address i, 0..31) keeps its trigger type in bits [5:4]: 0 = level high, 1 = rising edge, 2 = level low, 3 = falling edge. Level pending follows the input one clock late. Edge pending latches on the detected edge. Word 66 reads the pending bits, with source i at bit i.
- R4: Types 2 and 3 are accepted only for sources whose bit is set in the external-source parameter (default: sources 30 and 31). For an internal source such a write leaves the stored type unchanged but still updates the priority.
- R5: Mode bits [2:0] hold the priority, 0 (lowest) to 7 (highest). Among pending, enabled sources the highest priority wins, and on a tie the lowest source number wins.
- R6: When a request is being made, reading word 64 returns the winner's vector (word 32+i). The same read pushes the winner onto the stack and clears its edge-pending bit. A level source stays pending.
- R7: `irq_n` is low exactly when some pending, enabled source exists and either the stack is empty or the winner's priority is strictly above the top-of-stack priority with the stack not full.
- R8: Reading word 64 while no request is made returns the spurious vector (word 72, read/write). It does not change the stack, and the status word then reads 0 until the next acknowledge or end-of-service.
- R9: Word 65 reads the source number at the top of the stack, or 0 when the stack is empty.
- R10: Any write to word 71 pops one stack level, whatever the data, and word 71 reads 0. Eight such writes empty a full stack, and a write to an empty stack has no effect.
- R11: A disabled source still latches pending, which is visible in word 66, but it never drives `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Interrupt source inputs, synchronous to clk |
| bus_addr | input | 7 | Word address |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe; vector-port side effects occur at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address and current state |
| irq_n | output | 1 | Active-low interrupt request to the core |

## Verification
The assertions assume that the source inputs are already synchronous to `clk`. They also assume that read and write strobes are never raised together and that every address is held steady for the whole strobe cycle. The stimulus drives all inputs shortly after a rising edge, raises one strobe per bus operation, and inserts an idle cycle between operations. The stack-depth bound relies on priorities strictly rising with each push. The bench therefore reaches the full stack only through eight sources with priorities 0 to 7 acknowledged in rising order.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int DW     = 32,
  parameter int DEPTH  = 8,
  parameter logic [NSRC-1:0] EXT_SRC = NSRC'(32'hC000_0000)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [$clog2(NSRC)+1:0] bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_n
);
  localparam int IDX_W  = $clog2(NSRC);
  localparam int ADDR_W = IDX_W + 2;
  localparam int SP_W   = $clog2(DEPTH + 1);
  localparam int ST_W   = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(2*NSRC + 0);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(2*NSRC + 1);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(2*NSRC + 2);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(2*NSRC + 3);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(2*NSRC + 4);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(2*NSRC + 5);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2*NSRC + 6);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(2*NSRC + 7);
  localparam logic [ADDR_W-1:0] A_SPU  = ADDR_W'(2*NSRC + 8);
  localparam logic [1:0] T_HIGH = 2'd0, T_RISE = 2'd1, T_LOW = 2'd2, T_FALL = 2'd3;

  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [1:0]        trig_q [NSRC];
  logic [DW-1:0]     vec_q  [NSRC];
  logic [NSRC-1:0]   en_q, pend_q, pend_d, in_q;
  logic [DW-1:0]     spu_q;
  logic [PRIO_W-1:0] stk_prio [DEPTH];
  logic [IDX_W-1:0]  stk_src  [DEPTH];
  logic [SP_W-1:0]   sp_q;
  logic              spur_q;

  wire [IDX_W-1:0] sel     = bus_addr[IDX_W-1:0];
  wire             is_mode = bus_addr[ADDR_W-1:IDX_W] == 2'b00;
  wire             is_vec  = bus_addr[ADDR_W-1:IDX_W] == 2'b01;
  wire             en_wr   = bus_wr && bus_addr == A_EN;
  wire             dis_wr  = bus_wr && bus_addr == A_DIS;
  wire             clr_wr  = bus_wr && bus_addr == A_CLR;
  wire             eoi_wr  = bus_wr && bus_addr == A_EOI;
  wire             vec_rd  = bus_rd && bus_addr == A_VEC;

  wire [NSRC-1:0]  act   = pend_q & en_q;
  wire [ST_W-1:0]  top_i = (sp_q == '0) ? '0 : ST_W'(sp_q - 1'b1);
  wire [PRIO_W-1:0] top_prio = stk_prio[top_i];

  logic             win_any;
  logic [PRIO_W-1:0] win_prio;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    win_any  = 1'b0;
    win_prio = '0;
    win_idx  = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (act[i] && (!win_any || prio_q[i] >= win_prio)) begin
        win_any  = 1'b1;
        win_prio = prio_q[i];
        win_idx  = IDX_W'(i);
      end
  end

  wire req     = win_any && (sp_q == '0 || (win_prio > top_prio && sp_q != SP_W'(DEPTH)));
  wire ack     = vec_rd && req;
  wire spur_rd = vec_rd && !req;
  assign irq_n = ~req;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic hit, drop;
    always_comb begin
      case (trig_q[g])
        T_RISE:  hit = src_in[g] & ~in_q[g];
        T_FALL:  hit = ~src_in[g] & in_q[g];
        default: hit = 1'b0;
      endcase
      drop = (ack && win_idx == IDX_W'(g)) || (clr_wr && bus_wdata[g]);
      case (trig_q[g])
        T_HIGH:  pend_d[g] = src_in[g];
        T_LOW:   pend_d[g] = ~src_in[g];
        default: pend_d[g] = hit | (pend_q[g] & ~drop);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      pend_q <= '0;
      en_q   <= '0;
      spu_q  <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        trig_q[i] <= T_HIGH;
        vec_q[i]  <= '0;
      end
    end else begin
      in_q   <= src_in;
      pend_q <= pend_d;
      if (en_wr)  en_q <= en_q | bus_wdata[NSRC-1:0];
      if (dis_wr) en_q <= en_q & ~bus_wdata[NSRC-1:0];
      if (bus_wr && bus_addr == A_SPU) spu_q <= bus_wdata;
      if (bus_wr && is_vec) vec_q[sel] <= bus_wdata;
      if (bus_wr && is_mode) begin
        prio_q[sel] <= bus_wdata[PRIO_W-1:0];
        if (EXT_SRC[sel] || !bus_wdata[5]) trig_q[sel] <= bus_wdata[5:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= '0;
      spur_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        stk_prio[i] <= '0;
        stk_src[i]  <= '0;
      end
    end else if (ack) begin
      stk_prio[ST_W'(sp_q)] <= win_prio;
      stk_src[ST_W'(sp_q)]  <= win_idx;
      sp_q   <= sp_q + 1'b1;
      spur_q <= 1'b0;
    end else if (eoi_wr) begin
      if (sp_q != '0) sp_q <= sp_q - 1'b1;
      spur_q <= 1'b0;
    end else if (spur_rd) begin
      spur_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_mode) begin
      bus_rdata[PRIO_W-1:0] = prio_q[sel];
      bus_rdata[5:4]        = trig_q[sel];
    end else if (is_vec) begin
      bus_rdata = vec_q[sel];
    end else begin
      case (bus_addr)
        A_VEC:   bus_rdata = req ? vec_q[win_idx] : spu_q;
        A_CUR:   bus_rdata = (sp_q == '0 || spur_q) ? '0 : DW'(stk_src[top_i]);
        A_PEND:  bus_rdata = DW'(pend_q);
        A_ENA:   bus_rdata = DW'(en_q);
        A_SPU:   bus_rdata = spu_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH));
  a_r6_push_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !irq_n) |=> sp_q == $past(sp_q) + 1'b1);
  a_r10_pop_on_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !bus_rd && sp_q != '0) |=> sp_q == $past(sp_q) - 1'b1);
  a_r7_req_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (pend_q & en_q) != '0);
  a_r8_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_n) |-> bus_rdata == spu_q);
  a_r8_spurious_keeps_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_n && !bus_wr) |=> $stable(sp_q));
  a_r2_disable_all: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_wr && (&bus_wdata[NSRC-1:0])) |=> (irq_n && en_q == '0));
endmodule

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src = '0, wdata = '0;
  logic [6:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic        irq_n;
  int checks = 0, fails = 0;
  localparam logic [31:0] EXT = 32'hC000_0000;

  vec_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_in(src), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n));

  always #2 clk = ~clk;

  int m_prio [32];
  int m_trig [32];
  logic [31:0] m_vec [32];
  logic [31:0] m_en, m_pend, m_inq, m_spu;
  int stk_p[$];
  int stk_s[$];
  bit m_spur;

  function automatic void m_win(output bit any, output int p, output int s);
    any = 0; p = 0; s = 0;
    for (int i = 0; i < 32; i++)
      if (m_pend[i] && m_en[i] && (!any || m_prio[i] > p)) begin
        any = 1; p = m_prio[i]; s = i;
      end
  endfunction

  function automatic bit m_req();
    bit any; int p, s;
    m_win(any, p, s);
    if (!any) return 0;
    if (stk_p.size() == 0) return 1;
    return (p > stk_p[$]) && (stk_p.size() < 8);
  endfunction

  function automatic logic [31:0] m_read(int a);
    bit any; int p, s;
    m_win(any, p, s);
    if (a < 32) return (32'(m_trig[a]) << 4) | 32'(m_prio[a]);
    if (a < 64) return m_vec[a-32];
    case (a)
      64: return m_req() ? m_vec[s] : m_spu;
      65: return (stk_s.size() == 0 || m_spur) ? 32'd0 : 32'(stk_s[$]);
      66: return m_pend;
      67: return m_en;
      72: return m_spu;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_trig[i] = 0; m_vec[i] = 0; end
      m_en = 0; m_pend = 0; m_inq = 0; m_spu = 0; m_spur = 0;
      stk_p.delete(); stk_s.delete();
    end else begin
      bit any, req, ack, spr; int p, s;
      logic [31:0] np;
      m_win(any, p, s);
      req = m_req();
      ack = rd && addr == 64 && req;
      spr = rd && addr == 64 && !req;
      for (int i = 0; i < 32; i++) begin
        bit e;
        case (m_trig[i])
          0: np[i] = src[i];
          2: np[i] = ~src[i];
          default: begin
            e = (m_trig[i] == 1) ? (src[i] && !m_inq[i]) : (!src[i] && m_inq[i]);
            if (e) np[i] = 1;
            else if ((ack && s == i) || (wr && addr == 70 && wdata[i])) np[i] = 0;
            else np[i] = m_pend[i];
          end
        endcase
      end
      if (wr) begin
        if (addr < 32) begin
          m_prio[addr] = int'(wdata[2:0]);
          if (EXT[addr] || !wdata[5]) m_trig[addr] = int'(wdata[5:4]);
        end else if (addr < 64) m_vec[addr-32] = wdata;
        else if (addr == 68) m_en = m_en | wdata;
        else if (addr == 69) m_en = m_en & ~wdata;
        else if (addr == 72) m_spu = wdata;
      end
      if (ack) begin
        stk_p.push_back(p); stk_s.push_back(s); m_spur = 0;
      end else if (wr && addr == 71) begin
        if (stk_p.size() != 0) begin void'(stk_p.pop_back()); void'(stk_s.pop_back()); end
        m_spur = 0;
      end else if (spr) m_spur = 1;
      m_pend = np;
      m_inq = src;
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (irq_n !== !m_req()) begin
      fails++;
      $display("FAIL R7 irq_n model: got %0b expected %0b at %0t", irq_n, !m_req(), $time);
    end
    if (rd) begin
      logic [31:0] ex;
      ex = m_read(int'(addr));
      checks++;
      if (rdata !== ex) begin
        fails++;
        $display("FAIL R6/R8 rdata model addr %0d: got %h expected %h", addr, rdata, ex);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(posedge clk); #1; addr = 7'(a); rd = 1'b1; wr = 1'b0;
    @(negedge clk); d = rdata;
    @(posedge clk); #1; rd = 1'b0;
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(posedge clk); #1; addr = 7'(a); wdata = d; wr = 1'b1; rd = 1'b0;
    @(posedge clk); #1; wr = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(posedge clk); #1; src = src | m;
    @(posedge clk); #1; src = src & ~m;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_rd(string tag, int a, logic [31:0] exp);
    logic [31:0] d;
    rd_reg(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    chk("R1 irq_n after reset", 32'(irq_n), 32'd1);
    expect_rd("R1 vector port", 64, 0);
    expect_rd("R1 status", 65, 0);
    expect_rd("R1 enable mask", 67, 0);
    expect_rd("R1 pending", 66, 0);
    expect_rd("R1 spurious", 72, 0);
    expect_rd("R1 mode word", 4, 0);

    for (int i = 0; i < 32; i++) wr_reg(32 + i, 32'h100 + 32'(i));
    wr_reg(72, 32'hDEAD);

    wr_reg(68, 32'hF0);
    expect_rd("R2 enable set", 67, 32'hF0);
    wr_reg(69, 32'h30);
    expect_rd("R2 disable part", 67, 32'hC0);
    wr_reg(69, 32'hFFFF_FFFF);
    expect_rd("R2 disable all", 67, 0);

    wr_reg(5, 32'h12);
    pulse(32'h20);
    expect_rd("R11 disabled pending latched", 66, 32'h20);
    chk("R11 disabled no request", 32'(irq_n), 1);
    wr_reg(68, 32'h20);
    chk("R7 request after enable", 32'(irq_n), 0);
    expect_rd("R6 vector of source 5", 64, 32'h105);
    chk("R7 request drops after ack", 32'(irq_n), 1);
    expect_rd("R6 edge pending cleared", 66, 0);
    expect_rd("R9 status source 5", 65, 5);
    wr_reg(71, 32'h1234);
    expect_rd("R10 status after eoi", 65, 0);

    wr_reg(3, 32'h14); wr_reg(9, 32'h14); wr_reg(20, 32'h16);
    wr_reg(68, 32'h0010_0208);
    pulse(32'h0010_0208);
    expect_rd("R5 highest priority wins", 64, 32'h114);
    chk("R7 lower priority blocked", 32'(irq_n), 1);
    wr_reg(71, 0);
    chk("R7 request after unwind", 32'(irq_n), 0);
    expect_rd("R5 tie lowest index", 64, 32'h103);
    chk("R7 equal priority blocked", 32'(irq_n), 1);
    wr_reg(71, 0);
    expect_rd("R5 tie second", 64, 32'h109);
    wr_reg(71, 0);
    chk("R7 idle", 32'(irq_n), 1);

    wr_reg(1, 32'h11); wr_reg(2, 32'h15);
    wr_reg(68, 32'h6);
    pulse(32'h2);
    expect_rd("R6 low priority ack", 64, 32'h101);
    pulse(32'h4);
    chk("R7 preemption request", 32'(irq_n), 0);
    expect_rd("R6 preempting vector", 64, 32'h102);
    expect_rd("R9 nested status", 65, 2);
    wr_reg(71, 0);
    expect_rd("R9 resumed status", 65, 1);
    wr_reg(71, 0);
    expect_rd("R9 empty status", 65, 0);

    expect_rd("R8 spurious vector", 64, 32'hDEAD);
    expect_rd("R8 status after spurious", 65, 0);
    pulse(32'h4);
    expect_rd("R6 ack source 2", 64, 32'h102);
    pulse(32'h8);
    chk("R7 blocked under level 5", 32'(irq_n), 1);
    expect_rd("R8 spurious while nested", 64, 32'hDEAD);
    expect_rd("R8 status zero while nested", 65, 0);
    wr_reg(71, 0);
    chk("R8 stack kept, pop reopens", 32'(irq_n), 0);
    expect_rd("R8 pending served after pop", 64, 32'h103);
    wr_reg(71, 0);

    for (int k = 0; k < 8; k++) wr_reg(10 + k, 32'h10 | 32'(k));
    wr_reg(68, 32'h0003_FC00);
    for (int k = 0; k < 8; k++) begin
      pulse(32'h400 << k);
      expect_rd("R10 nest push", 64, 32'h10A + 32'(k));
    end
    expect_rd("R10 full stack status", 65, 17);
    pulse(32'h400);
    chk("R10 full stack blocks", 32'(irq_n), 1);
    for (int k = 0; k < 7; k++) wr_reg(71, 32'(k));
    expect_rd("R10 seven pops", 65, 10);
    chk("R10 level 0 still blocks", 32'(irq_n), 1);
    wr_reg(71, 32'hFFFF_FFFF);
    expect_rd("R10 eight pops empty", 65, 0);
    chk("R10 request after unwind", 32'(irq_n), 0);
    expect_rd("R10 pending re-served", 64, 32'h10A);
    wr_reg(71, 0);
    wr_reg(71, 0);
    expect_rd("R10 pop on empty", 65, 0);
    expect_rd("R10 eoi reads zero", 71, 0);

    wr_reg(6, 32'h03);
    wr_reg(68, 32'h40);
    @(posedge clk); #1 src[6] = 1'b1;
    idle(2);
    chk("R3 level high request", 32'(irq_n), 0);
    expect_rd("R6 level ack", 64, 32'h106);
    chk("R7 level held below level", 32'(irq_n), 1);
    expect_rd("R6 level stays pending", 66, 32'h40);
    wr_reg(71, 0);
    chk("R3 level re-requests", 32'(irq_n), 0);
    src[6] = 1'b0;
    idle(2);
    chk("R3 level released", 32'(irq_n), 1);
    expect_rd("R3 level pending gone", 66, 0);

    wr_reg(69, 32'hFFFF_FFFF);
    wr_reg(7, 32'h13);
    wr_reg(7, 32'h24);
    expect_rd("R4 internal keeps type", 7, 32'h14);
    wr_reg(30, 32'h22);
    idle(2);
    expect_rd("R3 level low pending", 66, 32'h4000_0000);
    expect_rd("R4 external accepts low", 30, 32'h22);
    wr_reg(68, 32'h4000_0000);
    expect_rd("R3 level low vector", 64, 32'h11E);
    wr_reg(71, 0);
    @(posedge clk); #1 src[30] = 1'b1;
    idle(2);
    chk("R3 level low released", 32'(irq_n), 1);
    wr_reg(31, 32'h31);
    pulse(32'h8000_0000);
    idle(1);
    expect_rd("R3 falling edge latched", 66, 32'h8000_0000);

    wr_reg(69, 32'hFFFF_FFFF);
    pulse(32'h220);
    expect_rd("R2 edges latched before clear", 66, 32'h8000_0220);
    wr_reg(70, 32'hFFFF_FFFF);
    expect_rd("R2 clear all", 66, 0);
    chk("R2 idle after clear", 32'(irq_n), 1);

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule